// File: doc/BRIEF.md
# Two-Output Level Interrupt Router

This block collects up to 32 level-sensitive interrupt lines from peripherals, brings them into the clock domain through a short synchronizer, and combines them into two CPU interrupt lines. Software controls the block through a small 32-bit register bus. Each source has an enable bit. The enable bits are changed only through two write ports: one sets bits and the other clears bits, so no read-modify-write is needed. A per-source route bit chooses which of the two CPU lines that source drives.

The top enable bit is not a source. It gates both CPU lines together. Software reads the synchronized levels without masking, and reads two masked pending views, one for each CPU line. To pick the source to service, it takes the lowest set bit of a pending view. No acknowledge exists: a pending bit clears only when the peripheral drops its line or software disables the source.

Top module: `irq_router`

## Requirements
- R1: After reset the enable mask and route mask are zero, both CPU lines are low, and reads of offsets 0x34 and 0x20 return zero.
- R2: A read of offset 0x30 returns the source levels after a 2-stage synchronizer, with no masking applied.
- R3: A write to offset 0x34 sets each enable bit whose data bit is 1 and leaves enable bits whose data bit is 0 unchanged.
- R4: A write to offset 0x38 clears each enable bit whose data bit is 1. A read of offset 0x38 returns zero.
- R5: While enable bit 31 is 0, both CPU lines stay low, whatever the pending state.
- R6: A route bit of 0 (set through offset 0x20) sends the source to line 0 and its pending view at offset 0x00. A route bit of 1 sends it to line 1 and the view at 0x04. Each view is raw AND enable AND the route condition for bits 0..30. Bit 31 of both views reads 0, and the views are not gated by bit 31.
- R7: Line n is high when enable bit 31 is set and the pending view for line n has any bit set. It stays high while the source is held high and falls when the source drops, with no acknowledge.
- R8: Read data is registered and appears with rd_valid one clock after rd_en. Unmapped offsets read zero. Writes to the read-only offsets 0x00, 0x04 and 0x30 change no state.
- R9: A read of offset 0x34 returns the full enable mask, including bit 31.
- R10: A change on a source line reaches the CPU line on the third rising edge after it is applied. After two edges the CPU line still holds its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rd_valid | output | 1 | rdata is valid this cycle |
| src_lvl | input | 32 | Peripheral interrupt levels, asynchronous |
| cpu_irq0 | output | 1 | CPU interrupt line 0 |
| cpu_irq1 | output | 1 | CPU interrupt line 1 |

## Verification
The assertions assume that wr_en and rd_en are never high in the same cycle. They also assume that each strobe lasts exactly one cycle per access, so every write affects the masks at the next edge and every read produces exactly one valid cycle. The stimulus drives all bus signals and source levels on the falling edge and issues one access at a time through tasks. This keeps those assumptions true and keeps the synchronizer inputs stable around each sampling edge. Source levels are changed only while the bus is idle, so the expected pending views are set by the mask state at the time of the read.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned REG_AW = 8;
  localparam logic [REG_AW-1:0] OFS_VIEW0  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_VIEW1  = 8'h04;
  localparam logic [REG_AW-1:0] OFS_ROUTE  = 8'h20;
  localparam logic [REG_AW-1:0] OFS_LEVEL  = 8'h30;
  localparam logic [REG_AW-1:0] OFS_SETEN  = 8'h34;
  localparam logic [REG_AW-1:0] OFS_CLREN  = 8'h38;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_VIEW0, SEL_VIEW1, SEL_ROUTE, SEL_LEVEL, SEL_SETEN, SEL_CLREN
  } reg_sel_e;

  function automatic reg_sel_e decode(input logic [REG_AW-1:0] a);
    case (a)
      OFS_VIEW0: return SEL_VIEW0;
      OFS_VIEW1: return SEL_VIEW1;
      OFS_ROUTE: return SEL_ROUTE;
      OFS_LEVEL: return SEL_LEVEL;
      OFS_SETEN: return SEL_SETEN;
      OFS_CLREN: return SEL_CLREN;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= '0;
          else     stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[s] <= '0;
          else     stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [NSRC-1:0]   wdata,
  output logic [NSRC-1:0]   en_mask,
  output logic [NSRC-1:0]   route_mask
);
  reg_sel_e sel;
  assign sel = decode(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_mask    <= '0;
      route_mask <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_SETEN: en_mask    <= en_mask | wdata;
        SEL_CLREN: en_mask    <= en_mask & ~wdata;
        SEL_ROUTE: route_mask <= wdata;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/irq_mask.sv
module irq_mask #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] raw,
  input  logic [NSRC-1:0] en_mask,
  input  logic [NSRC-1:0] route_mask,
  output logic [NSRC-1:0] view0,
  output logic [NSRC-1:0] view1,
  output logic            irq0,
  output logic            irq1
);
  localparam int unsigned GBIT = NSRC - 1;
  localparam logic [NSRC-1:0] SRC_BITS = {1'b0, {(NSRC-1){1'b1}}};

  always_comb begin
    view0 = raw & en_mask & ~route_mask & SRC_BITS;
    view1 = raw & en_mask &  route_mask & SRC_BITS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq0 <= 1'b0;
      irq1 <= 1'b0;
    end else begin
      irq0 <= en_mask[GBIT] & (|view0);
      irq1 <= en_mask[GBIT] & (|view1);
    end
  end
endmodule

// File: rtl/irq_rdmux.sv
module irq_rdmux
  import irq_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [NSRC-1:0]   view0,
  input  logic [NSRC-1:0]   view1,
  input  logic [NSRC-1:0]   route_mask,
  input  logic [NSRC-1:0]   raw,
  input  logic [NSRC-1:0]   en_mask,
  output logic [NSRC-1:0]   rdata,
  output logic              rd_valid
);
  logic [NSRC-1:0] mux;

  always_comb begin
    case (decode(addr))
      SEL_VIEW0: mux = view0;
      SEL_VIEW1: mux = view1;
      SEL_ROUTE: mux = route_mask;
      SEL_LEVEL: mux = raw;
      SEL_SETEN: mux = en_mask;
      default:   mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= mux;
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_pkg::*;
#(
  parameter int unsigned NSRC        = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [NSRC-1:0]   wdata,
  output logic [NSRC-1:0]   rdata,
  output logic              rd_valid,
  input  logic [NSRC-1:0]   src_lvl,
  output logic              cpu_irq0,
  output logic              cpu_irq1
);
  logic [NSRC-1:0] raw, en_mask, route_mask, view0, view1;

  irq_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(src_lvl), .q(raw)
  );

  irq_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .en_mask(en_mask), .route_mask(route_mask)
  );

  irq_mask #(.NSRC(NSRC)) u_mask (
    .clk(clk), .rst(rst), .raw(raw), .en_mask(en_mask),
    .route_mask(route_mask), .view0(view0), .view1(view1),
    .irq0(cpu_irq0), .irq1(cpu_irq1)
  );

  irq_rdmux #(.NSRC(NSRC)) u_rdmux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .view0(view0), .view1(view1), .route_mask(route_mask), .raw(raw),
    .en_mask(en_mask), .rdata(rdata), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [REG_AW-1:0] addr,
  input logic [NSRC-1:0]   wdata,
  input logic [NSRC-1:0]   rdata,
  input logic              rd_valid,
  input logic [NSRC-1:0]   en_mask,
  input logic              cpu_irq0,
  input logic              cpu_irq1
);
  localparam int unsigned GBIT = NSRC - 1;

  assert_seten_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_SETEN) |=> ((en_mask & $past(wdata)) == $past(wdata)));

  assert_keep_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_SETEN) |=> ((en_mask & $past(en_mask)) == $past(en_mask)));

  assert_clren_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_CLREN) |=> ((en_mask & $past(wdata)) == '0));

  assert_clrread_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_CLREN) |=> (rdata == '0));

  assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(en_mask[GBIT]) |-> (!cpu_irq0 && !cpu_irq1));

  assert_rdvalid_R8: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_noread_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  assert_ro_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == OFS_LEVEL || addr == OFS_VIEW0 || addr == OFS_VIEW1))
      |=> $stable(en_mask));
endmodule

bind irq_router irq_router_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .en_mask(en_mask),
  .cpu_irq0(cpu_irq0), .cpu_irq1(cpu_irq1)
);

// File: tb/test_irq_router.sv
module test_irq_router;
  localparam time PERIOD = 10ns;
  localparam int unsigned WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, src_lvl = '0;
  logic        rd_valid, cpu_irq0, cpu_irq1;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [31:0] m_en = '0, m_route = '0;

  always #(PERIOD/2) clk = ~clk;

  irq_router i_irq_router (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .src_lvl(src_lvl),
    .cpu_irq0(cpu_irq0), .cpu_irq1(cpu_irq1)
  );

  function automatic logic [31:0] v0();
    return src_lvl & m_en & ~m_route & 32'h7fff_ffff;
  endfunction
  function automatic logic [31:0] v1();
    return src_lvl & m_en & m_route & 32'h7fff_ffff;
  endfunction

  always @(negedge clk) begin
    if (rd_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R8: unexpected read data %h, expected none", rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: read got %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 8'h34) m_en = m_en | d;
    if (a == 8'h38) m_en = m_en & ~d;
    if (a == 8'h20) m_route = d;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_out(input logic e0, input logic e1, input string t);
    n_chk++;
    if (cpu_irq0 !== e0 || cpu_irq1 !== e1) begin
      n_fail++;
      $display("FAIL %s: lines got %b%b expected %b%b", t, cpu_irq1, cpu_irq0, e1, e0);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_out(1'b0, 1'b0, "R1");
    rd(8'h34, 32'h0, "R1");
    rd(8'h20, 32'h0, "R1");

    // R2 raw levels, no masking
    src_lvl = 32'h0000_0201; settle();
    rd(8'h30, 32'h0000_0201, "R2");
    rd(8'h00, 32'h0, "R6");
    chk_out(1'b0, 1'b0, "R1");

    // sources enabled, global still off
    wr(8'h34, 32'h0000_0201);
    rd(8'h34, 32'h0000_0201, "R9");
    rd(8'h00, v0(), "R6");
    settle();
    chk_out(1'b0, 1'b0, "R5");

    // global on, earlier bits kept
    wr(8'h34, 32'h8000_0000);
    rd(8'h34, 32'h8000_0201, "R3");
    settle();
    chk_out(1'b1, 1'b0, "R7");

    // route bit 9 to line 1
    wr(8'h20, 32'h0000_0200);
    rd(8'h20, 32'h0000_0200, "R6");
    rd(8'h00, 32'h0000_0001, "R6");
    rd(8'h04, 32'h0000_0200, "R6");
    settle();
    chk_out(1'b1, 1'b1, "R6");

    // disable source 0
    wr(8'h38, 32'h0000_0001);
    rd(8'h34, 32'h8000_0200, "R4");
    rd(8'h38, 32'h0, "R4");
    settle();
    chk_out(1'b0, 1'b1, "R4");

    // bit 31 never pending
    src_lvl = 32'h8000_0200; settle();
    rd(8'h04, 32'h0000_0200, "R6");
    rd(8'h00, 32'h0, "R6");

    // level behaviour and latency
    src_lvl = 32'h0; settle();
    chk_out(1'b0, 1'b0, "R7");
    @(negedge clk) src_lvl = 32'h0000_0200;
    @(negedge clk);
    @(negedge clk);
    chk_out(1'b0, 1'b0, "R10");
    @(negedge clk);
    chk_out(1'b0, 1'b1, "R10");
    repeat (20) @(negedge clk);
    chk_out(1'b0, 1'b1, "R7");

    // read-only writes ignored, unmapped reads zero
    wr(8'h30, 32'hffff_ffff);
    wr(8'h00, 32'hffff_ffff);
    wr(8'h04, 32'h0);
    rd(8'h34, 32'h8000_0200, "R8");
    rd(8'h20, 32'h0000_0200, "R8");
    rd(8'h10, 32'h0, "R8");
    settle();
    chk_out(1'b0, 1'b1, "R8");

    // clear all
    wr(8'h38, 32'hffff_ffff);
    rd(8'h34, 32'h0, "R4");
    settle();
    chk_out(1'b0, 1'b0, "R4");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R8: %0d reads got no data expected 0 left", exp_q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule